// File: doc/BRIEF.md
# SDRAM Auto-Refresh Command Sequencer

This block sits on the controller side of an SDRAM interface and issues auto-refresh commands when asked to. A refresh request loads the number of refreshes to perform. The block raises a busy flag and then waits for the access arbiter to give it the command bus. If the arbiter reports that any bank still holds an open row, the block first closes all banks with one precharge-all command. It then waits the row-precharge time and issues the refresh commands. It never sends a bank address, because the device's internal counter picks the row and bank. It never follows a refresh with a precharge, because the device closes the row by itself.

After each refresh, the block holds off the next command for the full refresh cycle time. This applies to a further refresh in the same burst and to any access the main scheduler wants to make afterwards. Busy stays high until that last wait has expired. The surrounding scheduler uses busy as its signal that the bus is free again.

The control flow has six states:
- IDLE: drives NOP and accepts a request.
- ARB: waits for the grant.
- PALL: the precharge-all command cycle.
- TRP_WAIT: waits out the rest of the row-precharge time.
- AREF: the refresh command cycle.
- TRC_WAIT: waits out the rest of the refresh cycle time.

The transitions are:
- IDLE→ARB when a request is seen.
- ARB→PALL when the grant arrives with a bank open.
- ARB→AREF when the grant arrives with all banks closed.
- PALL→TRP_WAIT, then TRP_WAIT→AREF when its timer expires.
- AREF→TRC_WAIT.
- TRC_WAIT→AREF when refreshes remain and the timer expires.
- TRC_WAIT→IDLE when the burst is done and the timer expires.

Top module: `sdram_refresh_seq`

## Requirements
- R1: `busy` rises in the cycle after `ref_req` is sampled high while the block is idle. A `ref_req` that arrives while `busy` is high is ignored and adds no command.
- R2: No command other than NOP is driven before `bus_grant` has been sampled high in the waiting state. The first command appears in the cycle after that sample.
- R3: If `banks_open` is high when the grant is sampled, the first command is precharge-all: `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, `a10`=1. The first refresh follows exactly TRP cycles after it. `a10` is high in no other cycle.
- R4: If `banks_open` is low when the grant is sampled, the first refresh is driven in the cycle right after the grant sample.
- R5: A refresh command lasts one cycle, with `cke`=1, `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1 and `a10`=0.
- R6: A request issues as many refreshes as `ref_count` holds, and a value of 0 counts as 1. Consecutive refreshes are exactly TRC cycles apart.
- R7: No precharge follows a refresh. `busy` falls exactly TRC cycles after the last refresh of the burst.
- R8: Every cycle that is not a command cycle drives NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1, `a10`=0). `cke` is 1 at all times out of reset.
- R9: While reset is held and right after it, the block is idle: `busy`=0 and the pins drive NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | input | 1 | Refresh request, sampled while idle |
| ref_count | input | CNT_W | Number of refreshes for this request (0 counts as 1) |
| banks_open | input | 1 | High when at least one bank has an open row |
| bus_grant | input | 1 | Command bus granted by the access arbiter |
| cke | output | 1 | Clock enable pin |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, set for precharge-all |
| busy | output | 1 | Sequencer owns the bus or is timing a refresh |

## Verification
The hardest case to reach from the ports is the one where every timing path meets at once. A refresh burst whose first refresh comes after a precharge-all and a delayed grant must keep exact TRP and TRC spacing all the way to the release of busy, and a stray request in the middle must be ignored. The bench sweeps the grant delay, the `banks_open` state and every burst count from 0 to 4. For each combination it computes the expected command and busy value for every cycle arithmetically. Each run also pulses an extra request while the block is busy, so any command that request adds shows up as a mismatch in the trace.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARB,
        ST_PALL,
        ST_TRP_WAIT,
        ST_AREF,
        ST_TRC_WAIT
    } ref_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PALL,
        CMD_AREF
    } ref_cmd_e;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } sdram_pins_t;

endpackage

// File: rtl/ref_wait_timer.sv
module ref_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ref_burst_counter.sv
module ref_burst_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             none_left
);
    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= (load_val == '0) ? CNT_W'(1) : load_val;
        end else if (dec && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign none_left = (rem_q == '0);
endmodule

// File: rtl/ref_cmd_encoder.sv
module ref_cmd_encoder
    import sdram_ref_pkg::*;
(
    input  ref_cmd_e    cmd,
    output sdram_pins_t pins
);
    always_comb begin
        pins = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
        unique case (cmd)
            CMD_NOP: ;
            CMD_PALL: begin
                pins.ras_n = 1'b0;
                pins.we_n  = 1'b0;
                pins.a10   = 1'b1;
            end
            CMD_AREF: begin
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
    import sdram_ref_pkg::*;
#(
    parameter int TRP   = 3,
    parameter int TRC   = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_req,
    input  logic [CNT_W-1:0] ref_count,
    input  logic             banks_open,
    input  logic             bus_grant,
    output logic             cke,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic             a10,
    output logic             busy
);
    localparam int MAXW   = (TRP > TRC) ? TRP : TRC;
    localparam int TMR_W  = $clog2(MAXW + 1);
    localparam int TRP_LD = (TRP > 2) ? TRP - 2 : 0;
    localparam int TRC_LD = (TRC > 2) ? TRC - 2 : 0;

    ref_state_e  state_q, state_d;
    ref_cmd_e    cmd;
    sdram_pins_t pins;
    logic        tmr_load, tmr_expired;
    logic [TMR_W-1:0] tmr_val;
    logic        accept, none_left;

    assign accept = (state_q == ST_IDLE) && ref_req;

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state_q == ST_PALL) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TRP_LD);
        end else if (state_q == ST_AREF) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(TRC_LD);
        end
    end

    ref_wait_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ref_burst_counter #(.CNT_W(CNT_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_val  (ref_count),
        .dec       (state_q == ST_AREF),
        .none_left (none_left)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (ref_req) state_d = ST_ARB;
            ST_ARB:      if (bus_grant) state_d = banks_open ? ST_PALL : ST_AREF;
            ST_PALL:     state_d = ST_TRP_WAIT;
            ST_TRP_WAIT: if (tmr_expired) state_d = ST_AREF;
            ST_AREF:     state_d = ST_TRC_WAIT;
            ST_TRC_WAIT: if (tmr_expired) state_d = none_left ? ST_IDLE : ST_AREF;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cmd  = CMD_NOP;
        busy = 1'b1;
        unique case (state_q)
            ST_IDLE:     busy = 1'b0;
            ST_ARB:      ;
            ST_PALL:     cmd = CMD_PALL;
            ST_TRP_WAIT: ;
            ST_AREF:     cmd = CMD_AREF;
            ST_TRC_WAIT: ;
            default:     busy = 1'b0;
        endcase
    end

    ref_cmd_encoder u_enc (
        .cmd  (cmd),
        .pins (pins)
    );

    assign cke   = pins.cke;
    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
    assign a10   = pins.a10;
endmodule

// File: rtl/sdram_refresh_seq_chk.sv
module sdram_refresh_seq_chk #(
    parameter int TRP = 3,
    parameter int TRC = 8
) (
    input logic clk,
    input logic rst_n,
    input logic ref_req,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic a10,
    input logic busy
);
    logic        is_ref, is_pre;
    logic [15:0] since_ref, since_pre;

    assign is_ref = !cs_n && !ras_n && !cas_n &&  we_n;
    assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ref <= 16'hFFFF;
            since_pre <= 16'hFFFF;
        end else begin
            since_ref <= is_ref ? 16'd1 : ((since_ref == 16'hFFFF) ? since_ref : since_ref + 16'd1);
            since_pre <= is_pre ? 16'd1 : ((since_pre == 16'hFFFF) ? since_pre : since_pre + 16'd1);
        end
    end

    assert_busy_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ref_req));
    assert_cmd_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref || is_pre) |-> busy);
    assert_pre_to_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (32'(since_pre) >= TRP));
    assert_a10_pall_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        a10 |-> is_pre);
    assert_ref_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (cke && !a10));
    assert_ref_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (32'(since_ref) >= TRC));
    assert_no_pre_after_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (32'(since_ref) >= TRC));
    assert_busy_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (32'(since_ref) >= TRC));
    assert_cke_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cke && !cs_n);
endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(.TRP(TRP), .TRC(TRC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_req (ref_req),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .a10     (a10),
    .busy    (busy)
);

// File: tb/tb_sdram_refresh_seq.sv
module tb_sdram_refresh_seq;
    localparam int TRP   = 3;
    localparam int TRC   = 6;
    localparam int CNT_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_req = 1'b0;
    logic [CNT_W-1:0] ref_count = '0;
    logic banks_open = 1'b0;
    logic bus_grant = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, a10, busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sdram_refresh_seq #(.TRP(TRP), .TRC(TRC), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_count(ref_count),
        .banks_open(banks_open), .bus_grant(bus_grant),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .a10(a10), .busy(busy)
    );

    // 0 = NOP, 1 = precharge-all, 2 = refresh, 3 = anything else
    function automatic int decode();
        if (!cs_n && ras_n && cas_n && we_n && !a10) return 0;
        if (!cs_n && !ras_n && cas_n && !we_n && a10) return 1;
        if (!cs_n && !ras_n && !cas_n && we_n && !a10) return 2;
        return 3;
    endfunction

    task automatic check_cycle(input string tag, input int c, input int exp_cmd, input bit exp_busy);
        int act;
        act = decode();
        checks++;
        if (act != exp_cmd || busy != exp_busy || cke != 1'b1) begin
            fails++;
            $display("FAIL %s cycle %0d: cmd=%0d busy=%0b cke=%0b expected cmd=%0d busy=%0b cke=1",
                     tag, c, act, busy, cke, exp_cmd, exp_busy);
        end
    endtask

    // g: grant delay in cycles, bo: banks_open, n: ref_count
    task automatic run(input int g, input bit bo, input int n);
        int c0, r0, neff, end_c, exp_cmd;
        string tag;
        c0    = 2 + g;
        r0    = bo ? c0 + TRP : c0;
        neff  = (n == 0) ? 1 : n;
        end_c = r0 + neff * TRC;
        @(negedge clk);
        ref_req    = 1'b1;
        ref_count  = CNT_W'(n);
        banks_open = bo;
        bus_grant  = 1'b0;
        for (int c = 1; c <= end_c + 2; c++) begin
            @(negedge clk);
            ref_req = 1'b0;
            exp_cmd = 0;
            tag = "R8";
            if (bo && c == c0) begin exp_cmd = 1; tag = "R3"; end
            else if (c >= r0 && c < end_c && ((c - r0) % TRC) == 0) begin
                exp_cmd = 2;
                tag = bo ? "R3/R5/R6" : "R4/R5/R6";
            end else if (c < c0) tag = "R2";
            else if (c >= end_c - 1) tag = "R7";
            else if (c == 1) tag = "R1";
            check_cycle(tag, c, exp_cmd, (c < end_c));
            if (c == 1 + g) bus_grant = 1'b1;
            if (c == c0 + 1) ref_req = 1'b1; // R1: stray request while busy
        end
        bus_grant  = 1'b0;
        banks_open = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_cycle("R9", 0, 0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_cycle("R9", 0, 0, 1'b0);
        for (int g = 0; g < 3; g++)
            for (int b = 0; b < 2; b++)
                for (int n = 0; n < 5; n++)
                    run(g, b[0], n);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule